// File: doc/BRIEF.md
# Windowed Watchdog with Clear-Token Sequencing

This block supervises a processor by demanding a periodic clear that must land inside a timing window and must carry the right token. A free-running elapsed-cycle counter starts from zero after reset and after every accepted clear. A clear that comes while the count is still below the early bound, a clear whose token does not match the expected value, or no accepted clear before the count reaches the late bound, all make the block assert a system reset pulse.

The expected token is held in a sequence register. It starts at a parameterised initial value and steps by one, wrapping, on every accepted clear, so software must keep an ordered record of its own clears. The current token is visible on an output. After a reset pulse of a parameterised length, the counter and the token restart from their initial values. A cause code tells which fault fired last. Only the block's own reset input clears that code.

Integration is a clock, a synchronous active-low reset, a one-cycle clear strobe with a token bus, and the three outputs. The window bounds are elaboration parameters, and elaboration stops if the late bound is not above the early bound.

Top module: `seqwdt_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block leaves that edge with `sys_rst_o` = 0, `cause_o` = 0 (none) and `seq_o` = `SEQ_INIT` (0 by default).
- R2: A clear sampled while the elapsed count is below `T_EARLY` fires a reset whatever its token, with `cause_o` = 1 (early).
- R3: If no clear is accepted, the reset fires at the edge that samples an elapsed count of `T_LATE`, with `cause_o` = 2 (late). The count is 0 in the first cycle after reset release, and each edge adds one to it.
- R4: A clear sampled with the count in [`T_EARLY`, `T_LATE`-1] and `clr_op` equal to `seq_o` is accepted. No reset follows, the count restarts at 0, and `seq_o` steps by one and wraps modulo 2^`SEQ_W`.
- R5: A clear sampled inside the window with `clr_op` different from `seq_o` fires a reset with `cause_o` = 3 (sequence mismatch).
- R6: Both window edges are inclusive for acceptance: a count of exactly `T_EARLY` and a count of exactly `T_LATE`-1 are accepted, and a count of `T_EARLY`-1 is early.
- R7: `sys_rst_o` goes high after the firing edge and stays high for exactly `RST_LEN` cycles. In the cycle after it falls, the count is 0 and `seq_o` = `SEQ_INIT`. `seq_o` keeps its pre-fault value while the pulse lasts.
- R8: `cause_o` changes only when a reset fires or when `rst_n` is low. It keeps its value through and after the pulse, and a later fault overwrites it.
- R9: Clears that arrive while `sys_rst_o` is high have no effect: the pulse length, `cause_o` and the restarted `seq_o` are the same as without them.
- R10: When a clear with a correct token is sampled at the same edge as the late deadline, the late fault wins: `cause_o` = 2 and `seq_o` does not advance.
- R11: Elaboration fails when `T_LATE` is not greater than `T_EARLY`, or when `T_EARLY` is below 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also clears the cause code |
| clr_req | input | 1 | One-cycle clear strobe |
| clr_op | input | SEQ_W | Token carried by the clear |
| sys_rst_o | output | 1 | System reset pulse, `RST_LEN` cycles long |
| cause_o | output | 2 | Last fault: 0 none, 1 early, 2 late, 3 mismatch |
| seq_o | output | SEQ_W | Token the next clear must carry |

## Verification
Two functions can meet in one cycle: the late deadline and a well-formed clear. The bench sets this up by waiting exactly `T_LATE` cycles after a restart and then strobing a clear with the correct token, so the clear is sampled at the deadline edge. The result is judged at the ports: the reset must fire with the late code and the token must stay where it was. A second overlap comes from clears issued during the reset pulse. There the pulse length, the held cause and the restarted token show that the clears did nothing.

// File: rtl/seqwdt_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings of the sequenced windowed watchdog.
// Assumes a 2-bit cause field visible at the top-level port.
package seqwdt_pkg;

    // Reason recorded for the most recent watchdog-generated reset
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_EARLY = 2'd1,
        CAUSE_LATE  = 2'd2,
        CAUSE_SEQ   = 2'd3
    } cause_e;

endpackage

// File: rtl/seqwdt_window.sv
`timescale 1ns/1ps
// Module: seqwdt_window
// Counts cycles since the last restart and classifies the count against
// the early and late bounds. The count saturates at T_LATE.
// Assumes: T_LATE > T_EARLY >= 1; restart has priority over counting.
module seqwdt_window #(
    parameter int T_EARLY = 20,
    parameter int T_LATE  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic too_soon,
    output logic in_window,
    output logic expired
);
    localparam int CNT_W = $clog2(T_LATE + 1);
    localparam logic [CNT_W-1:0] EARLY_C = CNT_W'(T_EARLY);
    localparam logic [CNT_W-1:0] LATE_C  = CNT_W'(T_LATE);

    logic [CNT_W-1:0] elapsed;

    // Elapsed-cycle counter: cleared on reset or restart, saturating at the late bound
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            elapsed <= '0;
        end else if (elapsed != LATE_C) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Window classification of the current count
    always_comb begin
        too_soon  = (elapsed < EARLY_C);
        expired   = (elapsed == LATE_C);
        in_window = !too_soon && !expired;
    end
endmodule

// File: rtl/seqwdt_seq.sv
`timescale 1ns/1ps
// Module: seqwdt_seq
// Holds the expected clear token, compares the incoming token with it,
// advances it by one (wrapping) on an accepted clear, and reloads it.
// Assumes: reload and advance are never requested in the same cycle.
module seqwdt_seq #(
    parameter int SEQ_W    = 8,
    parameter int SEQ_INIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             reload,
    input  logic [SEQ_W-1:0] op,
    output logic             match,
    output logic [SEQ_W-1:0] seq
);
    localparam logic [SEQ_W-1:0] INIT_C = SEQ_W'(SEQ_INIT);

    // Token register: initial value on reset or reload, increment on accept
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            seq <= INIT_C;
        end else if (advance) begin
            seq <= seq + 1'b1;
        end
    end

    // Token comparison against the expected value
    always_comb begin
        match = (op == seq);
    end
endmodule

// File: rtl/seqwdt_stretch.sv
`timescale 1ns/1ps
// Module: seqwdt_stretch
// Turns a one-cycle start into a pulse exactly RST_LEN cycles long and
// flags the final cycle of the pulse.
// Assumes: RST_LEN >= 1; start is ignored while the pulse is active.
module seqwdt_stretch #(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int LEN_W = $clog2(RST_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_C = LEN_W'(RST_LEN);

    logic [LEN_W-1:0] remain;

    // Remaining pulse cycles: loaded on start, counted down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else if (start) begin
            remain <= LEN_C;
        end
    end

    // Pulse level and final-cycle flag
    always_comb begin
        active = (remain != '0);
        last   = (remain == LEN_W'(1));
    end
endmodule

// File: rtl/seqwdt_top.sv
`timescale 1ns/1ps
// Module: seqwdt_top
// Windowed watchdog with token sequencing. A clear is accepted only with
// the count inside [T_EARLY, T_LATE-1] and with a token equal to the
// sequence register. An early clear, a wrong token, or reaching T_LATE
// fires a reset pulse of RST_LEN cycles. The late fault outranks a clear
// sampled in the same cycle. The cause code survives the pulse.
// Assumes: synchronous active-low rst_n; clr_req is a one-cycle strobe.
module seqwdt_top
    import seqwdt_pkg::*;
#(
    parameter int T_EARLY  = 20,
    parameter int T_LATE   = 60,
    parameter int RST_LEN  = 4,
    parameter int SEQ_W    = 8,
    parameter int SEQ_INIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_req,
    input  logic [SEQ_W-1:0] clr_op,
    output logic             sys_rst_o,
    output logic [1:0]       cause_o,
    output logic [SEQ_W-1:0] seq_o
);
    // R11: elaboration-time check of the window bounds
    if (T_LATE <= T_EARLY || T_EARLY < 1) begin : g_bad_window
        $error("seqwdt_top: T_LATE must exceed T_EARLY and T_EARLY must be >= 1");
    end

    logic   too_soon, in_window, expired;
    logic   tok_ok, pulse_on, pulse_last;
    logic   clr_live, fire_late, fire_early, fire_seq, fire_any, accept;
    logic   restart;
    cause_e cause_q, cause_d;

    seqwdt_window #(
        .T_EARLY (T_EARLY),
        .T_LATE  (T_LATE)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .too_soon  (too_soon),
        .in_window (in_window),
        .expired   (expired)
    );

    seqwdt_seq #(
        .SEQ_W    (SEQ_W),
        .SEQ_INIT (SEQ_INIT)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept),
        .reload  (pulse_last),
        .op      (clr_op),
        .match   (tok_ok),
        .seq     (seq_o)
    );

    seqwdt_stretch #(
        .RST_LEN (RST_LEN)
    ) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fire_any),
        .active (pulse_on),
        .last   (pulse_last)
    );

    // Fault and accept decode; nothing is evaluated while the pulse is active
    always_comb begin
        clr_live   = clr_req && !pulse_on;
        fire_late  = expired && !pulse_on;
        fire_early = clr_live && too_soon;
        fire_seq   = clr_live && in_window && !tok_ok;
        fire_any   = fire_late || fire_early || fire_seq;
        accept     = clr_live && in_window && tok_ok;
        restart    = accept || fire_any || pulse_on;
    end

    // Cause priority: late first, then early, then token mismatch
    always_comb begin
        if (fire_late) begin
            cause_d = CAUSE_LATE;
        end else if (fire_early) begin
            cause_d = CAUSE_EARLY;
        end else begin
            cause_d = CAUSE_SEQ;
        end
    end

    // Cause register: cleared only by rst_n, overwritten by each new fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
        end else if (fire_any) begin
            cause_q <= cause_d;
        end
    end

    // Output drive
    always_comb begin
        sys_rst_o = pulse_on;
        cause_o   = cause_q;
    end
endmodule

// File: rtl/seqwdt_chk.sv
`timescale 1ns/1ps
// Module: seqwdt_chk
// Port-level properties of seqwdt_top, bound into every instance.
// Assumes: the same parameter values as the bound top.
module seqwdt_chk #(
    parameter int T_LATE  = 60,
    parameter int RST_LEN = 4,
    parameter int SEQ_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_rst_o,
    input logic [1:0]       cause_o,
    input logic [SEQ_W-1:0] seq_o
);
    int               plen;
    int               quiet;
    logic [SEQ_W-1:0] seq_prev;

    // Length of the current reset pulse in cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !sys_rst_o) plen <= 0;
        else                      plen <= plen + 1;
    end

    // Cycles since the last token change or pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet    <= 0;
            seq_prev <= '0;
        end else begin
            seq_prev <= seq_o;
            if (sys_rst_o || seq_o != seq_prev) quiet <= 0;
            else                                quiet <= quiet + 1;
        end
    end

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (plen == RST_LEN));

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst_o && !$past(sys_rst_o) && seq_o != $past(seq_o))
        |-> (seq_o == SEQ_W'($past(seq_o) + 1'b1)));

    // R8
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sys_rst_o) |-> $stable(cause_o));

    // R2
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> (cause_o != 2'd0));

    // R3
    late_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_o |-> (quiet <= T_LATE + 2));
endmodule

bind seqwdt_top seqwdt_chk #(
    .T_LATE  (T_LATE),
    .RST_LEN (RST_LEN),
    .SEQ_W   (SEQ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_o (sys_rst_o),
    .cause_o   (cause_o),
    .seq_o     (seq_o)
);

// File: tb/sim_seqwdt_top.sv
`timescale 1ns/1ps
module sim_seqwdt_top;
    localparam int T_EARLY = 20;
    localparam int T_LATE  = 60;
    localparam int RST_LEN = 4;
    localparam int SEQ_W   = 8;
    localparam int NVEC    = 10;

    // vector: {gap[7:0], good_token, expected cause[1:0]}; cause 0 = accepted
    localparam logic [10:0] VEC [NVEC] = '{
        {8'd30, 1'b1, 2'd0},   // R4 plain accept
        {8'd20, 1'b1, 2'd0},   // R6 lower edge
        {8'd59, 1'b1, 2'd0},   // R6 upper edge
        {8'd19, 1'b1, 2'd1},   // R6/R2 one short of the window
        {8'd0,  1'b1, 2'd1},   // R2 immediate clear
        {8'd40, 1'b0, 2'd3},   // R5 wrong token
        {8'd25, 1'b1, 2'd0},   // R4
        {8'd25, 1'b0, 2'd3},   // R5
        {8'd45, 1'b1, 2'd0},   // R4
        {8'd5,  1'b0, 2'd1}    // R2 early wins over bad token
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_req = 1'b0;
    logic [SEQ_W-1:0] clr_op = '0;
    logic             sys_rst_o;
    logic [1:0]       cause_o;
    logic [SEQ_W-1:0] seq_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic [SEQ_W-1:0] exp_seq = '0;

    always #2.5 clk = ~clk;

    seqwdt_top #(
        .T_EARLY (T_EARLY),
        .T_LATE  (T_LATE),
        .RST_LEN (RST_LEN),
        .SEQ_W   (SEQ_W),
        .SEQ_INIT(0)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req   (clr_req),
        .clr_op    (clr_op),
        .sys_rst_o (sys_rst_o),
        .cause_o   (cause_o),
        .seq_o     (seq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe a clear at this negedge; returns at the next negedge
    task automatic clear(input logic [SEQ_W-1:0] op);
        clr_req = 1'b1;
        clr_op  = op;
        @(negedge clk);
        clr_req = 1'b0;
        clr_op  = '0;
    endtask

    // after a firing edge: check pulse length and restart values
    task automatic ride_pulse(input string req);
        chk({req, " pulse start"}, int'(sys_rst_o), 1);
        idle(RST_LEN - 1);
        chk({req, " pulse still high"}, int'(sys_rst_o), 1);
        idle(1);
        chk({req, " pulse ended"}, int'(sys_rst_o), 0);
        chk({req, " token restarted"}, int'(seq_o), 0);
        exp_seq = '0;
    endtask

    initial begin
        idle(3);
        chk("R1 sys_rst", int'(sys_rst_o), 0);
        chk("R1 cause", int'(cause_o), 0);
        chk("R1 seq", int'(seq_o), 0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] gap;
            logic       good;
            logic [1:0] ec;
            {gap, good, ec} = VEC[i];
            idle(int'(gap));
            clear(good ? exp_seq : exp_seq + 8'h55);
            if (ec == 2'd0) begin
                chk("R4 no reset on accept", int'(sys_rst_o), 0);
                chk("R4 token step", int'(seq_o), int'(SEQ_W'(exp_seq + 1'b1)));
                exp_seq = exp_seq + 1'b1;
            end else begin
                chk("R2/R5 fault cause", int'(cause_o), int'(ec));
                ride_pulse("R7");
                chk("R8 cause kept after pulse", int'(cause_o), int'(ec));
            end
        end

        // R3 late timeout from a fresh restart
        idle(T_LATE);
        chk("R3 not yet fired", int'(sys_rst_o), 0);
        idle(1);
        chk("R3 late cause", int'(cause_o), 2);
        ride_pulse("R3");
        chk("R8 late cause held", int'(cause_o), 2);

        // R1 reset input clears the cause
        rst_n = 1'b0;
        idle(2);
        chk("R1 cause cleared by rst_n", int'(cause_o), 0);
        rst_n = 1'b1;

        // R9 clears during pulse are ignored
        clear(exp_seq);
        chk("R9 early fired", int'(cause_o), 1);
        chk("R9 pulse high", int'(sys_rst_o), 1);
        clear(8'd0);
        chk("R9 pulse unchanged", int'(sys_rst_o), 1);
        clear(8'd7);
        idle(RST_LEN - 3);
        chk("R9 pulse still high", int'(sys_rst_o), 1);
        idle(1);
        chk("R9 pulse ended on time", int'(sys_rst_o), 0);
        chk("R9 cause unchanged", int'(cause_o), 1);
        chk("R9 token restarted", int'(seq_o), 0);
        exp_seq = '0;

        // R10 clear collides with the late deadline
        idle(30);
        clear(exp_seq);
        exp_seq = exp_seq + 1'b1;
        chk("R10 setup accept", int'(seq_o), int'(exp_seq));
        idle(T_LATE);
        clear(exp_seq);
        chk("R10 late wins", int'(cause_o), 2);
        chk("R10 token not advanced", int'(seq_o), int'(exp_seq));
        ride_pulse("R10");

        // R4 wrap of the token register
        for (int k = 0; k < (1 << SEQ_W); k++) begin
            idle(T_EARLY);
            clear(exp_seq);
            exp_seq = exp_seq + 1'b1;
            if (sys_rst_o) break;
        end
        chk("R4 token wrapped", int'(seq_o), 0);
        chk("R4 no reset during wrap run", int'(sys_rst_o), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule